// File: doc/BRIEF.md
# Digital CVSD Codec Core

This block is a continuously variable slope delta modulator that works only on digital words. One instance runs in one direction at a time. In encode mode it compares a signed audio sample with an internal signed estimate, sends one NRZ bit per clock, and moves the estimate up or down by the current step. In decode mode it takes one received bit per clock and rebuilds the same estimate. Either way, the estimate word is the reconstructed audio output.

The step size adapts. A short history of applied bits detects runs of equal bits. Each run feeds a leaky syllabic accumulator, and the accumulator's integer part gives the step. The estimate integrator also leaks toward zero. Two controls quiet the line. An active-low zeroing input clears the whole loop. An active-low transmit mask sends the quieting pattern but lets the loop keep running. An active-low level flag shows a loud estimate.

Top module: `cvsd_codec`

## Requirements
- R1: While `rst` is high at a rising edge, `est_out` becomes 0, `agc_n` is 1, and `tx_bit` is 0.
- R2: In encode mode (`dec_sel` = 0), the bit decided at a rising edge is 1 when `sample >= est_out`, compared as signed, and 0 otherwise. `tx_bit` takes that bit at the following falling edge and does not change at rising edges. A decoder fed this stream reproduces the encoder's estimate one clock later.
- R3: At each active edge the estimate becomes `est + step - (est >>> LEAK_SHIFT)` for bit 1, or `est - step - (est >>> LEAK_SHIFT)` for bit 0. The result saturates at -512 and +511 and never wraps.
- R4: The history holds the previous three applied bits. When all three are equal, the syllabic accumulator does not shrink on the next edge, so the step grows. With the input held at +400 after reset, the estimate passes 60 within 30 clocks.
- R5: Without a run, the accumulator does not grow. The step never falls below 1 and never rises above `STEP_MAX`. After reset, an alternating 1,0 bit stream moves the estimate exactly 1,0,1,0.
- R6: In decode mode (`dec_sel` = 1), `rx_bit` is taken at each rising edge and `sample` is ignored. `tx_bit` carries the alternating quieting pattern.
- R7: While `zero_n` is low, all loop state is cleared at each rising edge, so `est_out` reads 0 one clock later. `tx_bit` alternates 1/0 on every clock.
- R8: While `tx_mask_n` is low, `tx_bit` alternates on every clock. The loop keeps tracking `sample`, and `est_out` keeps moving.
- R9: `agc_n` is 0 exactly when `est_out >= 256` or `est_out <= -256`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| dec_sel | input | 1 | 0 = encode, 1 = decode |
| zero_n | input | 1 | Active-low loop clear with quieting output |
| tx_mask_n | input | 1 | Active-low transmit quieting, loop keeps running |
| sample | input | EST_W | Signed audio sample (encode mode) |
| rx_bit | input | 1 | Received NRZ bit (decode mode) |
| tx_bit | output | 1 | Transmitted NRZ bit, updated on falling edges |
| est_out | output | EST_W | Signed reconstructed estimate |
| agc_n | output | 1 | Low when estimate magnitude reaches half scale |

## Verification
A wrong step or a wrong estimate update in either instance shows up at once. In the encoder-to-decoder loop, the two estimate words stop matching with a one-clock offset on the first clock where the two loops differ. A fault in the run history or in the syllabic accumulator grows the step at the wrong time. That shows up within a few clocks, either as a departure from the exact 1,0 sequence under alternating bits or as a slow climb under a held input. A fault in the quieting path shows up as two equal `tx_bit` values on adjacent clocks. A fault in saturation shows up as a sign flip of `est_out` while a long run pins it.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;

    typedef enum logic {
        MODE_ENCODE = 1'b0,
        MODE_DECODE = 1'b1
    } cvsd_mode_e;

    // Per-cycle control decoded from the mode and quieting inputs
    typedef struct packed {
        logic clear;   // zeroing active: loop state cleared
        logic quiet;   // line carries alternating pattern
        logic active;  // loop advances this clock
    } cvsd_ctl_t;

    // Alternating 0/1 seed so that a fresh history never reads as a run
    function automatic logic [31:0] alt_seed(input int len);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < len) v[i] = i[0];
        end
        return v;
    endfunction

endpackage

// File: rtl/cvsd_run_detect.sv
module cvsd_run_detect
    import cvsd_pkg::*;
#(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic shift_en,
    input  logic bit_in,
    output logic run_hit
);
    localparam logic [31:0] SEED_W = alt_seed(RUN_LEN);
    localparam logic [RUN_LEN-1:0] SEED = SEED_W[RUN_LEN-1:0];

    logic [RUN_LEN-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hist_q <= SEED;
        end else if (shift_en) begin
            hist_q <= {hist_q[RUN_LEN-2:0], bit_in};
        end
    end

    // Run: every held bit equal
    assign run_hit = (&hist_q) | ~(|hist_q);

endmodule

// File: rtl/cvsd_syllabic.sv
module cvsd_syllabic #(
    parameter int SYL_W     = 16,
    parameter int FRAC      = 4,
    parameter int DECAY_SH  = 6,
    parameter int GAIN      = 16,
    parameter int STEP_MAX  = 64,
    parameter int STEP_W    = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              en,
    input  logic              run_hit,
    output logic [STEP_W-1:0] step,
    output logic [SYL_W-1:0]  acc
);
    localparam logic [SYL_W-1:0] STEP_LO = SYL_W'(1);
    localparam logic [SYL_W-1:0] STEP_HI = SYL_W'(STEP_MAX);

    logic [SYL_W-1:0] acc_q;
    logic [SYL_W:0]   acc_nxt;
    logic [SYL_W-1:0] raw;

    always_comb begin
        acc_nxt = {1'b0, acc_q} - ({1'b0, acc_q} >> DECAY_SH);
        if (run_hit) acc_nxt = acc_nxt + (SYL_W+1)'(GAIN);
        if (acc_nxt[SYL_W]) acc_nxt = {1'b0, {SYL_W{1'b1}}};
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= acc_nxt[SYL_W-1:0];
        end
    end

    always_comb begin
        raw = acc_q >> FRAC;
        if (raw < STEP_LO)      step = STEP_W'(STEP_LO);
        else if (raw > STEP_HI) step = STEP_W'(STEP_HI);
        else                    step = STEP_W'(raw);
    end

    assign acc = acc_q;

endmodule

// File: rtl/cvsd_estimator.sv
module cvsd_estimator #(
    parameter int EST_W    = 10,
    parameter int STEP_W   = 7,
    parameter int LEAK_SH  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    en,
    input  logic                    bit_val,
    input  logic [STEP_W-1:0]       step,
    output logic signed [EST_W-1:0] est
);
    localparam int WIDEST = (EST_W > STEP_W) ? EST_W : STEP_W;
    localparam int SUM_W  = WIDEST + 3;
    localparam logic signed [SUM_W-1:0] HI = SUM_W'((2 ** (EST_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] LO = -SUM_W'(2 ** (EST_W - 1));

    logic signed [EST_W-1:0] est_q;
    logic signed [SUM_W-1:0] est_x, step_x, leak_x, sum, sat;

    always_comb begin
        est_x  = {{(SUM_W-EST_W){est_q[EST_W-1]}}, est_q};
        step_x = {{(SUM_W-STEP_W){1'b0}}, step};
        leak_x = est_x >>> LEAK_SH;
        sum    = bit_val ? (est_x + step_x - leak_x) : (est_x - step_x - leak_x);
        if (sum > HI)      sat = HI;
        else if (sum < LO) sat = LO;
        else               sat = sum;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            est_q <= '0;
        end else if (en) begin
            est_q <= sat[EST_W-1:0];
        end
    end

    assign est = est_q;

endmodule

// File: rtl/cvsd_codec.sv
module cvsd_codec
    import cvsd_pkg::*;
#(
    parameter int EST_W      = 10,
    parameter int RUN_LEN    = 3,
    parameter int STEP_MAX   = 64,
    parameter int SYL_W      = 16,
    parameter int SYL_FRAC   = 4,
    parameter int SYL_SHIFT  = 6,
    parameter int SYL_GAIN   = 16,
    parameter int LEAK_SHIFT = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    dec_sel,
    input  logic                    zero_n,
    input  logic                    tx_mask_n,
    input  logic signed [EST_W-1:0] sample,
    input  logic                    rx_bit,
    output logic                    tx_bit,
    output logic signed [EST_W-1:0] est_out,
    output logic                    agc_n
);
    localparam int STEP_W = $clog2(STEP_MAX + 1);
    localparam logic signed [EST_W-1:0] HALF = EST_W'(2 ** (EST_W - 2));

    cvsd_mode_e              mode_e;
    cvsd_ctl_t               ctl;
    logic signed [EST_W-1:0] est_q;
    logic                    enc_bit;
    logic                    applied_bit;
    logic                    run_hit;
    logic [STEP_W-1:0]       step;
    logic [SYL_W-1:0]        syl_acc;
    logic                    decide_q;
    logic                    quiet_q;
    logic                    alt_q;

    assign mode_e = cvsd_mode_e'(dec_sel);

    always_comb begin
        ctl.clear  = !zero_n;
        ctl.quiet  = !zero_n || !tx_mask_n || (mode_e == MODE_DECODE);
        ctl.active = zero_n;
    end

    // Digital comparator against the running estimate
    assign enc_bit     = (sample >= est_q);
    assign applied_bit = (mode_e == MODE_DECODE) ? rx_bit : enc_bit;

    cvsd_run_detect #(
        .RUN_LEN (RUN_LEN)
    ) u_run (
        .clk      (clk),
        .rst      (rst),
        .clear    (ctl.clear),
        .shift_en (ctl.active),
        .bit_in   (applied_bit),
        .run_hit  (run_hit)
    );

    cvsd_syllabic #(
        .SYL_W    (SYL_W),
        .FRAC     (SYL_FRAC),
        .DECAY_SH (SYL_SHIFT),
        .GAIN     (SYL_GAIN),
        .STEP_MAX (STEP_MAX),
        .STEP_W   (STEP_W)
    ) u_syl (
        .clk     (clk),
        .rst     (rst),
        .clear   (ctl.clear),
        .en      (ctl.active),
        .run_hit (run_hit),
        .step    (step),
        .acc     (syl_acc)
    );

    cvsd_estimator #(
        .EST_W   (EST_W),
        .STEP_W  (STEP_W),
        .LEAK_SH (LEAK_SHIFT)
    ) u_est (
        .clk     (clk),
        .rst     (rst),
        .clear   (ctl.clear),
        .en      (ctl.active),
        .bit_val (applied_bit),
        .step    (step),
        .est     (est_q)
    );

    // Decision and quieting choice captured on the rising edge
    always_ff @(posedge clk) begin
        if (rst) begin
            decide_q <= 1'b0;
            quiet_q  <= 1'b0;
        end else begin
            decide_q <= ctl.clear ? 1'b0 : enc_bit;
            quiet_q  <= ctl.quiet;
        end
    end

    // Line output moves on the falling edge
    always_ff @(negedge clk) begin
        if (rst) begin
            alt_q  <= 1'b0;
            tx_bit <= 1'b0;
        end else begin
            alt_q  <= ~alt_q;
            tx_bit <= quiet_q ? ~alt_q : decide_q;
        end
    end

    assign est_out = est_q;
    assign agc_n   = !((est_q >= HALF) || (est_q <= -HALF));

endmodule

// File: rtl/cvsd_codec_chk.sv
module cvsd_codec_chk #(
    parameter int EST_W = 10,
    parameter int SYL_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    dec_sel,
    input logic                    zero_n,
    input logic                    tx_mask_n,
    input logic                    tx_bit,
    input logic signed [EST_W-1:0] est_out,
    input logic                    run_hit,
    input logic [SYL_W-1:0]        syl_acc,
    input logic                    applied_bit
);
    logic quiet_in;
    assign quiet_in = !zero_n || !tx_mask_n || dec_sel;

    assert_zero_clears_R7: assert property (@(posedge clk) disable iff (rst)
        !zero_n |=> (est_out == '0));

    assert_quiet_toggles_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(quiet_in) && $past(quiet_in, 2)) |-> (tx_bit != $past(tx_bit)));

    assert_run_grows_R4: assert property (@(posedge clk) disable iff (rst)
        (run_hit && zero_n) |=> (syl_acc >= $past(syl_acc)));

    assert_idle_decays_R5: assert property (@(posedge clk) disable iff (rst)
        (!run_hit && zero_n) |=> (syl_acc <= $past(syl_acc)));

    assert_no_wrap_up_R3: assert property (@(posedge clk) disable iff (rst)
        (zero_n && applied_bit && (est_out > 0)) |=> !est_out[EST_W-1]);

    assert_no_wrap_down_R3: assert property (@(posedge clk) disable iff (rst)
        (zero_n && !applied_bit && (est_out < 0)) |=> est_out[EST_W-1]);

endmodule

bind cvsd_codec cvsd_codec_chk #(
    .EST_W (EST_W),
    .SYL_W (SYL_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dec_sel     (dec_sel),
    .zero_n      (zero_n),
    .tx_mask_n   (tx_mask_n),
    .tx_bit      (tx_bit),
    .est_out     (est_out),
    .run_hit     (run_hit),
    .syl_acc     (syl_acc),
    .applied_bit (applied_bit)
);

// File: tb/cvsd_codec_test.sv
module cvsd_codec_test;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    // encoder side
    logic              rst_e, zero_e, mask_e;
    logic signed [9:0] smp_e;
    logic              enc_bit;
    logic signed [9:0] enc_est;
    logic              enc_agc;
    // decoder side
    logic              rst_d, zero_d;
    logic signed [9:0] smp_d;
    logic              loop_sel, bit_drv, dec_in;
    logic              dec_bit;
    logic signed [9:0] dec_est;
    logic              dec_agc;

    int n_run  = 0;
    int n_fail = 0;
    logic early_bit;
    bit done = 0;

    assign dec_in = loop_sel ? enc_bit : bit_drv;

    cvsd_codec uut (
        .clk(clk), .rst(rst_e), .dec_sel(1'b0), .zero_n(zero_e), .tx_mask_n(mask_e),
        .sample(smp_e), .rx_bit(1'b0), .tx_bit(enc_bit), .est_out(enc_est), .agc_n(enc_agc)
    );

    cvsd_codec dec (
        .clk(clk), .rst(rst_d), .dec_sel(1'b1), .zero_n(zero_d), .tx_mask_n(1'b1),
        .sample(smp_d), .rx_bit(dec_in), .tx_bit(dec_bit), .est_out(dec_est), .agc_n(dec_agc)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2 early_bit = enc_bit;
        #6;
    endtask

    function automatic bit loud(input int e);
        return (e >= 256) || (e <= -256);
    endfunction

    function automatic int tri_wave(input int i);
        int ph;
        ph = i % 128;
        if (ph < 64) return -300 + (ph * 600) / 64;
        return 300 - ((ph - 64) * 600) / 64;
    endfunction

    task automatic reset_all(input int smp);
        rst_e = 1; rst_d = 1; zero_e = 1; zero_d = 1; mask_e = 1;
        loop_sel = 1; bit_drv = 0; smp_d = 0;
        smp_e = 10'(smp);
        repeat (3) tick();
        rst_e = 0;
        tick();
        rst_d = 0;
    endtask

    task automatic test_reset();
        rst_e = 1; rst_d = 1; zero_e = 1; zero_d = 1; mask_e = 1;
        loop_sel = 1; bit_drv = 0; smp_e = 10'sd200; smp_d = 0;
        repeat (3) tick();
        chk(enc_est == 0, "R1", "estimate in reset", int'(enc_est), 0);
        chk(enc_agc == 1'b1, "R1", "agc_n in reset", int'(enc_agc), 1);
        chk(enc_bit == 1'b0, "R1", "tx_bit in reset", int'(enc_bit), 0);
        chk(dec_est == 0, "R1", "decoder estimate in reset", int'(dec_est), 0);
    endtask

    task automatic test_loopback();
        int prev_est, prev_dbit, prev_tx, smp;
        reset_all(tri_wave(0));
        smp_d = -10'sd400;  // R6: ignored by the decoder
        for (int i = 1; i < 512; i++) begin
            prev_est  = int'(enc_est);
            prev_dbit = int'(dec_bit);
            prev_tx   = int'(enc_bit);
            smp       = tri_wave(i);
            smp_e     = 10'(smp);
            tick();
            chk(int'(dec_est) == prev_est, "R2", "decoder tracks encoder", int'(dec_est), prev_est);
            chk(int'(enc_bit) == ((smp >= prev_est) ? 1 : 0), "R2", "decision bit",
                int'(enc_bit), (smp >= prev_est) ? 1 : 0);
            chk(int'(early_bit) == prev_tx, "R2", "tx_bit held over rising edge", int'(early_bit), prev_tx);
            chk(int'(dec_bit) != prev_dbit, "R6", "decode-mode tx_bit alternates", int'(dec_bit), 1 - prev_dbit);
            chk(enc_agc == !loud(int'(enc_est)), "R9", "agc_n vs estimate",
                int'(enc_agc), loud(int'(enc_est)) ? 0 : 1);
        end
    endtask

    task automatic test_growth();
        reset_all(400);
        repeat (29) tick();
        chk(int'(enc_est) > 60, "R4", "estimate after 30 clocks above 60", int'(enc_est), 61);
    endtask

    task automatic test_min_step();
        reset_all(0);
        loop_sel = 0;
        smp_d = 10'sd400;  // R6: ignored in decode mode
        for (int i = 0; i < 20; i++) begin
            bit_drv = ~i[0];
            tick();
            chk(int'(dec_est) == (i[0] ? 0 : 1), "R5", "minimum step under alternating bits",
                int'(dec_est), i[0] ? 0 : 1);
        end
    endtask

    task automatic test_saturation();
        bit neg_seen;
        reset_all(0);
        loop_sel = 0;
        bit_drv  = 1;
        neg_seen = 0;
        for (int i = 0; i < 200; i++) begin
            tick();
            if (dec_est < 0) neg_seen = 1;
        end
        chk(!neg_seen, "R3", "no wrap while pinned high", int'(neg_seen), 0);
        chk(int'(dec_est) == 511, "R3", "positive saturation", int'(dec_est), 511);
        chk(dec_agc == 1'b0, "R9", "agc_n at positive full scale", int'(dec_agc), 0);
        bit_drv = 0;
        repeat (300) tick();
        chk(int'(dec_est) == -512, "R3", "negative saturation", int'(dec_est), -512);
        chk(dec_agc == 1'b0, "R9", "agc_n at negative full scale", int'(dec_agc), 0);
    endtask

    task automatic test_zero();
        int prev;
        reset_all(400);
        repeat (20) tick();
        chk(int'(enc_est) != 0, "R7", "estimate moved before zeroing", int'(enc_est), 1);
        zero_e = 0;
        tick();
        chk(int'(enc_est) == 0, "R7", "estimate cleared one clock after zeroing", int'(enc_est), 0);
        for (int i = 0; i < 16; i++) begin
            prev = int'(enc_bit);
            tick();
            chk(int'(enc_bit) != prev, "R7", "alternating bits under zeroing", int'(enc_bit), 1 - prev);
            chk(int'(enc_est) == 0, "R7", "estimate held at zero", int'(enc_est), 0);
        end
        zero_e = 1;
    endtask

    task automatic test_mask();
        int prev, start_est;
        reset_all(300);
        mask_e = 0;
        tick();
        start_est = int'(enc_est);
        for (int i = 0; i < 20; i++) begin
            prev = int'(enc_bit);
            tick();
            chk(int'(enc_bit) != prev, "R8", "alternating bits under mask", int'(enc_bit), 1 - prev);
        end
        chk(int'(enc_est) > start_est, "R8", "loop keeps tracking under mask", int'(enc_est), start_est + 1);
        mask_e = 1;
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        test_reset();
        test_loopback();
        test_growth();
        test_min_step();
        test_saturation();
        test_zero();
        test_mask();
        done = 1;
        report();
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule